// File: doc/BRIEF.md
# Reloadable Core Clock Divider

This block derives one peripheral clock from a reference clock by integer division. Software programs the divide ratio through a small 32-bit register bus. A ratio written to the staging register does nothing by itself. The block adopts it only when a single control write sets both the per-clock reload-request bit and the shared reload-fire bit. The divider then switches at the end of the output period in progress, so every emitted period is a whole period of either the old ratio or the new one.

A separate enable bit gates the output. It sits at the reload-request bit position shifted up by `EN_SHIFT`. When software clears it, the current period runs to its end and the output then stays low. When software sets it again, the output restarts with a high phase. Internally a three-state machine runs the output: `ST_IDLE` (output held low), `ST_HIGH` and `ST_LOW`.

The transitions are:
- `ST_IDLE`→`ST_HIGH` when the enable bit is set.
- `ST_HIGH`→`ST_LOW` when the high count expires.
- `ST_LOW`→`ST_HIGH` at a period boundary while enabled. Any pending ratio is loaded here.
- `ST_LOW`→`ST_IDLE` at a period boundary while disabled.

Top module: `core_clkdiv`

## Requirements
- R1: After reset the control register reads 0, the ratio register reads 0x0000_0400 (active and staged ratio 4), and `clk_div` is low.
- R2: Writing the ratio register changes only the staged value. The output period is unchanged until a reload handshake.
- R3: A reload is accepted only when one control write (offset 0x0) has both bit 1 (reload request) and bit 8 (reload fire) set. A write with only one of the two leaves the period unchanged.
- R4: While enabled, each `clk_div` period lasts N reference cycles, where N is the active ratio. The output is high for floor(N/2) cycles and low for the rest.
- R5: Only ratios 4, 5, 6 and 8 are accepted. A handshake with any other staged value is ignored, and the active ratio is kept.
- R6: The active ratio changes only at the end of a low phase or while idle. Every complete output period is a legal whole period, with no shortened pulse.
- R7: The enable bit is control bit 1+EN_SHIFT (bit 25 by default). Clearing it lets the current period finish, and then `clk_div` stays low. Setting it restarts the output.
- R8: After a reload, a control write that clears bits 7:0 and bit 8 does not change the applied ratio.
- R9: The ratio register sits at byte offset RATIO_OFS (0x8 by default), with the ratio in bits 13:8. Writes to any other offset do not change the staged ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| clk_div | output | 1 | Divided clock output |

## Verification
The bench measures every output period and high time and runs each legal ratio (4, 5, 6, 8), so odd and even splits are both covered. Half-finished handshakes, with only the request bit or only the fire bit, must leave the period as it was. This separates a design that needs both bits from one that reacts to either. Illegal staged values (7, 0) and staging writes to the wrong offset must be ignored. The post-reload clear write must keep the new ratio, and disable and re-enable sequences show the output held low and then restarting.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } div_state_t;

    function automatic logic ratio_ok(input int r);
        return (r == 4) || (r == 5) || (r == 6) || (r == 8);
    endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
    parameter int AW        = 4,
    parameter int DW        = 32,
    parameter int RATIO_OFS = 8,
    parameter int RATIO_LSB = 8,
    parameter int RATIO_W   = 6,
    parameter int REQ_BIT   = 1,
    parameter int FIRE_BIT  = 8,
    parameter int EN_SHIFT  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    output logic               enable,
    output logic               pend_vld,
    output logic [RATIO_W-1:0] pend_ratio,
    input  logic               take
);
    import clkdiv_pkg::*;

    localparam int CTRL_OFS = 0;
    localparam int EN_BIT   = REQ_BIT + EN_SHIFT;
    localparam logic [DW-1:0] RATIO_RST = DW'(4) << RATIO_LSB;

    logic [DW-1:0]      ctrl_q;
    logic [DW-1:0]      ratio_q;
    logic [RATIO_W-1:0] staged;
    logic               ctrl_wr;
    logic               handshake;

    assign staged    = ratio_q[RATIO_LSB +: RATIO_W];
    assign ctrl_wr   = wr && (addr == AW'(CTRL_OFS));
    assign handshake = ctrl_wr && wdata[REQ_BIT] && wdata[FIRE_BIT];
    assign enable    = ctrl_q[EN_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            ratio_q <= RATIO_RST;
        end else if (wr) begin
            if (addr == AW'(CTRL_OFS))  ctrl_q  <= wdata;
            if (addr == AW'(RATIO_OFS)) ratio_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_vld   <= 1'b0;
            pend_ratio <= RATIO_W'(4);
        end else if (handshake && ratio_ok(int'(staged))) begin
            pend_vld   <= 1'b1;
            pend_ratio <= staged;
        end else if (take) begin
            pend_vld   <= 1'b0;
        end
    end

    always_comb begin
        if (addr == AW'(CTRL_OFS))       rdata = ctrl_q;
        else if (addr == AW'(RATIO_OFS)) rdata = ratio_q;
        else                             rdata = '0;
    end

    AST_RELOAD_NEEDS_BOTH_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_vld) |-> $past(ctrl_wr && wdata[REQ_BIT] && wdata[FIRE_BIT])) // R3
        else $error("pending reload without handshake");

    AST_PENDING_IS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vld |-> ratio_ok(int'(pend_ratio))) // R5
        else $error("illegal ratio pending");

endmodule

// File: rtl/clkdiv_fsm.sv
module clkdiv_fsm #(
    parameter int RATIO_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               pend_vld,
    input  logic [RATIO_W-1:0] pend_ratio,
    output logic               take,
    output logic               clk_out
);
    import clkdiv_pkg::*;

    div_state_t         state_q, state_n;
    logic [RATIO_W-1:0] cnt_q, cnt_n;
    logic [RATIO_W-1:0] act_q, act_n;
    logic [RATIO_W-1:0] hi_next, lo_act;
    logic               boundary;

    assign boundary = (state_q == ST_LOW) && (cnt_q == '0);
    assign take     = pend_vld && (boundary || state_q == ST_IDLE);
    assign act_n    = take ? pend_ratio : act_q;
    assign hi_next  = act_n >> 1;
    assign lo_act   = act_q - (act_q >> 1);

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) begin
                    state_n = ST_HIGH;
                    cnt_n   = hi_next - 1'b1;
                end
            end
            ST_HIGH: begin
                if (cnt_q == '0) begin
                    state_n = ST_LOW;
                    cnt_n   = lo_act - 1'b1;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            ST_LOW: begin
                if (cnt_q == '0) begin
                    if (enable) begin
                        state_n = ST_HIGH;
                        cnt_n   = hi_next - 1'b1;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            default: begin
                state_n = ST_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            act_q   <= RATIO_W'(4);
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            act_q   <= act_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_out <= 1'b0;
        else        clk_out <= (state_n == ST_HIGH);
    end

    AST_ACTIVE_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_ok(int'(act_q))) // R5
        else $error("active ratio illegal");

    AST_SWITCH_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_q) |-> $past((state_q == ST_LOW && cnt_q == '0) || state_q == ST_IDLE)) // R6
        else $error("ratio changed mid-period");

    AST_IDLE_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && state_q == ST_IDLE) |=> !clk_out) // R7
        else $error("output toggled while disabled");

    AST_HIGH_FALLS_TO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH && cnt_q == '0) |=> (state_q == ST_LOW)) // R4
        else $error("high phase did not end in low phase");

endmodule

// File: rtl/core_clkdiv.sv
module core_clkdiv #(
    parameter int AW        = 4,
    parameter int RATIO_OFS = 8,
    parameter int EN_SHIFT  = 24,
    parameter int RATIO_LSB = 8,
    parameter int RATIO_W   = 6
) (
    input  logic          clk_ref,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          clk_div
);
    logic               enable;
    logic               pend_vld;
    logic [RATIO_W-1:0] pend_ratio;
    logic               take;

    clkdiv_regs #(
        .AW(AW), .DW(32), .RATIO_OFS(RATIO_OFS), .RATIO_LSB(RATIO_LSB),
        .RATIO_W(RATIO_W), .REQ_BIT(1), .FIRE_BIT(8), .EN_SHIFT(EN_SHIFT)
    ) u_regs (
        .clk(clk_ref), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .enable(enable),
        .pend_vld(pend_vld), .pend_ratio(pend_ratio), .take(take)
    );

    clkdiv_fsm #(
        .RATIO_W(RATIO_W)
    ) u_fsm (
        .clk(clk_ref), .rst_n(rst_n), .enable(enable),
        .pend_vld(pend_vld), .pend_ratio(pend_ratio),
        .take(take), .clk_out(clk_div)
    );

endmodule

// File: tb/core_clkdiv_test.sv
module core_clkdiv_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] EN   = 32'h1 << 25;
    localparam logic [31:0] REQ  = 32'h1 << 1;
    localparam logic [31:0] FIRE = 32'h1 << 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        clk_div;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    core_clkdiv uut (
        .clk_ref(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_div(clk_div)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = '0;
    endtask

    // push two expected periods once old periods have drained, wait until scored
    task automatic expect_period(input int n);
        repeat (24) @(negedge clk);
        exp_q.push_back(n);
        exp_q.push_back(n);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // monitor: measures each complete period and high time at the falling clock edge
    int  cyc = 0, rise_t = 0, hi_cnt = 0, low_run = 0;
    bit  prev = 1'b0, have_rise = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (clk_div && !prev) begin
            if (have_rise) begin
                int per;
                per = cyc - rise_t;
                // R6: every full period is a legal whole period with the expected split
                chk((per == 4 || per == 5 || per == 6 || per == 8) && hi_cnt == per / 2,
                    "R6 period/high legal", per * 100 + hi_cnt, per * 100 + per / 2);
                if (exp_q.size() != 0) begin
                    int e;
                    e = exp_q.pop_front();
                    chk(per == e, "R4 period", per, e);
                end
            end
            have_rise = 1'b1;
            rise_t = cyc;
            hi_cnt = 1;
            low_run = 0;
        end else if (clk_div) begin
            hi_cnt++;
        end else begin
            low_run++;
            if (low_run > 8) have_rise = 1'b0;
        end
        prev = clk_div;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int highs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, d); chk(d == 32'h0, "R1 ctrl reset", d, 0);
        rd(4'h8, d); chk(d == 32'h400, "R1 ratio reset", d, 32'h400);
        highs = 0;
        repeat (20) begin @(negedge clk); if (clk_div) highs++; end
        chk(highs == 0, "R1 output low while disabled", highs, 0);

        // R4/R7 enable with reset ratio 4
        wr(4'h0, EN);
        expect_period(4);

        // R2 staging alone does nothing
        wr(4'h8, 32'd6 << 8);
        rd(4'h8, d); chk(d == (32'd6 << 8), "R9 ratio readback", d, 32'd6 << 8);
        expect_period(4); // R2

        // R3 half handshakes
        wr(4'h0, EN | REQ);
        expect_period(4); // R3 request only
        wr(4'h0, EN | FIRE);
        expect_period(4); // R3 fire only
        wr(4'h0, EN | REQ | FIRE);
        expect_period(6); // R3 full handshake

        // R8 clear write keeps applied ratio
        wr(4'h0, EN);
        rd(4'h0, d); chk(d == EN, "R8 ctrl after clear", d, EN);
        expect_period(6);

        // R4 odd and largest ratios
        wr(4'h8, 32'd5 << 8); wr(4'h0, EN | REQ | FIRE); wr(4'h0, EN);
        expect_period(5);
        wr(4'h8, 32'd8 << 8); wr(4'h0, EN | REQ | FIRE); wr(4'h0, EN);
        expect_period(8);

        // R5 illegal values ignored
        wr(4'h8, 32'd7 << 8); wr(4'h0, EN | REQ | FIRE); wr(4'h0, EN);
        expect_period(8);
        wr(4'h8, 32'd0); wr(4'h0, EN | REQ | FIRE); wr(4'h0, EN);
        expect_period(8);

        // R9 wrong offset does not stage
        wr(4'h8, 32'd5 << 8); wr(4'h0, EN | REQ | FIRE); wr(4'h0, EN);
        expect_period(5);
        wr(4'h4, 32'd4 << 8);
        rd(4'h4, d); chk(d == 32'h0, "R9 other offset reads zero", d, 0);
        wr(4'h0, EN | REQ | FIRE); wr(4'h0, EN);
        expect_period(5); // R9

        // R7 disable then re-enable
        wr(4'h0, 32'h0);
        repeat (10) @(negedge clk);
        highs = 0;
        repeat (40) begin @(negedge clk); if (clk_div) highs++; end
        chk(highs == 0, "R7 held low after disable", highs, 0);
        wr(4'h8, 32'd6 << 8); wr(4'h0, REQ | FIRE); wr(4'h0, EN);
        expect_period(6); // R7 restart, reload while idle

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule